// File: doc/BRIEF.md
# Multi-Select Static Word Memory

This block is a 128-word by 8-bit storage array for synthesis. It has a shared data bus, split into a data-in port, a data-out port and an output enable. Five chip-select lines gate it. Two of them are active high and three are active low. The block is enabled only when all five are at their active level together. An active-low read strobe and an active-low write strobe then pick one of four modes: read, write, standby or not selected. Both strobes low together is a fifth, conflicting case, and the block treats it as inert.

All inputs are sampled on the rising clock edge. The mode is decoded from the sampled values. A write takes effect on the cycle in which a selected, low write strobe is seen high again. The word and the address stored are the ones sampled together with that rising strobe. This matches the rule that data must be held up to the end of the write pulse. Read data comes combinationally from the array at the sampled address, so a new address shows on the port after one edge.

Top module: `multisel_ram`

## Requirements
- R1: The block is selected only when the sampled `selHi0` and `selHi1` are 1 and the sampled `selLo0`, `selLo1` and `selLo2` are 0. In the bench these lines are packed as {selHi0, selLo0, selLo1, selHi1, selLo2}, and the matching pattern is 5'b10010.
- R2: If any one select line is at its inactive level, `dataOe` is 0, `dataOut` is 0 and no word is stored, whatever the strobes are.
- R3: In read mode (selected, `rdN`=0, `wrN`=1), `dataOe` is 1 and `dataOut` equals the word stored at the sampled address. Both are visible after the clock edge that samples these inputs.
- R4: While read mode persists, a changed address is reflected on `dataOut` after the next edge. With the address held, `dataOut` holds too.
- R5: A write commits when one sampled cycle is in write mode (selected, `wrN`=0, `rdN`=1) and the next sampled cycle is standby (selected, both strobes 1). The address and data stored are those sampled in the standby cycle, not those from the write-low cycle.
- R6: In write mode `dataOe` is 0.
- R7: In standby `dataOe` is 0, and the stored contents are unchanged unless R5 applies.
- R8: With both strobes 0 while selected, `dataOe` is 0 and no write is committed. A write phase that passes through this state before the strobes return high stores nothing.
- R9: A write strobe that rises while the block is deselected, or while `rdN` is 0, stores nothing.
- R10: After reset `dataOe` and `dataOut` are 0 and no write is pending. The array contents are not initialised.
- R11: Whenever `dataOe` is 0, `dataOut` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all inputs sampled on the rising edge |
| rstN | input | 1 | Asynchronous active-low reset of the sampling and mode registers |
| addr | input | 7 | Word address |
| selHi0 | input | 1 | Select line, active high |
| selLo0 | input | 1 | Select line, active low |
| selLo1 | input | 1 | Select line, active low |
| selHi1 | input | 1 | Select line, active high |
| selLo2 | input | 1 | Select line, active low |
| rdN | input | 1 | Read strobe, active low |
| wrN | input | 1 | Write strobe, active low |
| dataIn | input | 8 | Bus value to be written |
| dataOut | output | 8 | Bus value driven in read mode, 0 otherwise |
| dataOe | output | 1 | Bus output enable, 1 only in read mode |

## Verification
A wrong mode decode appears one edge after the offending inputs. It shows as a raised or missing `dataOe`, checked against the select and strobe pattern the bench drove. A write committed on the wrong transition, or with the wrong sampled address or data, stays hidden in the array until that word is read back. For this reason every location is written with data different from its write-low value, and the array is swept with reads. The conflict, deselect-on-rise and read-on-rise cases are each followed by a read of the targeted word. This exposes a stray commit within a few cycles.

// File: rtl/multisel_ram_pkg.sv
package multisel_ram_pkg;

  typedef enum logic [2:0] {
    MODE_OFF,
    MODE_IDLE,
    MODE_READ,
    MODE_WRITE,
    MODE_CLASH
  } ramMode_t;

  typedef struct packed {
    logic commit;
    logic drive;
  } ramStrobe_t;

endpackage

// File: rtl/multisel_ram_ctrl.sv
module multisel_ram_ctrl
  import multisel_ram_pkg::*;
#(
  parameter int SEL_W = 5,
  parameter logic [SEL_W-1:0] SEL_ACTIVE = 5'b10010
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [SEL_W-1:0] selIn,
  input  logic             rdN,
  input  logic             wrN,
  output ramStrobe_t       strb
);

  logic [SEL_W-1:0] selQ;
  logic [SEL_W-1:0] matchBit;
  logic             rdNQ;
  logic             wrNQ;
  logic             selected;
  ramMode_t         mode;
  ramMode_t         prevMode;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      selQ     <= ~SEL_ACTIVE;
      rdNQ     <= 1'b1;
      wrNQ     <= 1'b1;
      prevMode <= MODE_OFF;
    end else begin
      selQ     <= selIn;
      rdNQ     <= rdN;
      wrNQ     <= wrN;
      prevMode <= mode;
    end
  end

  for (genvar i = 0; i < SEL_W; i++) begin : gSelMatch
    assign matchBit[i] = selQ[i] ~^ SEL_ACTIVE[i];
  end

  assign selected = &matchBit;

  always_comb begin
    if (!selected)              mode = MODE_OFF;
    else if (!rdNQ && !wrNQ)    mode = MODE_CLASH;
    else if (!rdNQ)             mode = MODE_READ;
    else if (!wrNQ)             mode = MODE_WRITE;
    else                        mode = MODE_IDLE;
  end

  always_comb begin
    strb.drive  = (mode == MODE_READ);
    strb.commit = (prevMode == MODE_WRITE) && (mode == MODE_IDLE);
  end

  // R3
  rd_drive_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.drive |-> ($past(rdN) == 1'b0 && $past(wrN) == 1'b1));

  // R5
  commit_src_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |-> ($past(wrN, 2) == 1'b0 && $past(wrN) == 1'b1 && $past(rdN) == 1'b1));

  // R2
  desel_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(selIn) != SEL_ACTIVE) |-> (!strb.drive && !strb.commit));

  // R8
  clash_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(rdN) == 1'b0 && $past(wrN) == 1'b0) |-> (strb == '0));

endmodule

// File: rtl/multisel_ram_data.sv
module multisel_ram_data
  import multisel_ram_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] dataIn,
  input  logic              rdN,
  input  ramStrobe_t        strb,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [ADDR_W-1:0] addrQ;
  logic [DATA_W-1:0] dataQ;
  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ <= '0;
      dataQ <= '0;
    end else begin
      addrQ <= addr;
      dataQ <= dataIn;
    end
  end

  always_ff @(posedge clk) begin
    if (strb.commit) store[addrQ] <= dataQ;
  end

  assign dataOe  = strb.drive;
  assign dataOut = strb.drive ? store[addrQ] : '0;

  // R5
  store_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |=> (store[$past(addrQ)] == $past(dataQ)));

  // R11
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    $past(rdN) |-> (dataOut == '0));

  // R4
  hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($past(strb.drive) && strb.drive && $stable(addrQ)) |-> $stable(dataOut));

endmodule

// File: rtl/multisel_ram.sv
module multisel_ram
  import multisel_ram_pkg::*;
#(
  parameter int ADDR_W = 7,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              selHi0,
  input  logic              selLo0,
  input  logic              selLo1,
  input  logic              selHi1,
  input  logic              selLo2,
  input  logic              rdN,
  input  logic              wrN,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe
);

  localparam int SEL_W = 5;
  localparam logic [SEL_W-1:0] SEL_ACTIVE = 5'b10010;

  logic [SEL_W-1:0] selIn;
  ramStrobe_t       strb;

  assign selIn = {selHi0, selLo0, selLo1, selHi1, selLo2};

  multisel_ram_ctrl #(
    .SEL_W      (SEL_W),
    .SEL_ACTIVE (SEL_ACTIVE)
  ) uCtrl (
    .clk   (clk),
    .rstN  (rstN),
    .selIn (selIn),
    .rdN   (rdN),
    .wrN   (wrN),
    .strb  (strb)
  );

  multisel_ram_data #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) uData (
    .clk     (clk),
    .rstN    (rstN),
    .addr    (addr),
    .dataIn  (dataIn),
    .rdN     (rdN),
    .strb    (strb),
    .dataOut (dataOut),
    .dataOe  (dataOe)
  );

  // R10
  reset_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (!dataOe && dataOut == '0));

endmodule

// File: tb/multisel_ram_test.sv
module multisel_ram_test;

  localparam logic [4:0] ON = 5'b10010;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic [6:0] addr = '0;
  logic       selHi0, selLo0, selLo1, selHi1, selLo2;
  logic       rdN = 1'b1;
  logic       wrN = 1'b1;
  logic [7:0] dataIn = '0;
  logic [7:0] dataOut;
  logic       dataOe;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0] model [128];
  logic       expOeQ [$];
  logic [7:0] expDataQ [$];
  string      tagQ [$];

  always #4 clk = ~clk;

  multisel_ram uut (
    .clk(clk), .rstN(rstN), .addr(addr),
    .selHi0(selHi0), .selLo0(selLo0), .selLo1(selLo1), .selHi1(selHi1), .selLo2(selLo2),
    .rdN(rdN), .wrN(wrN), .dataIn(dataIn), .dataOut(dataOut), .dataOe(dataOe)
  );

  initial {selHi0, selLo0, selLo1, selHi1, selLo2} = ~ON;

  task automatic step(input logic [6:0] a, input logic [4:0] s, input logic r, input logic w,
                      input logic [7:0] d, input logic eOe, input logic [7:0] eData, input string tag);
    @(negedge clk);
    addr = a;
    {selHi0, selLo0, selLo1, selHi1, selLo2} = s;
    rdN = r;
    wrN = w;
    dataIn = d;
    expOeQ.push_back(eOe);
    expDataQ.push_back(eData);
    tagQ.push_back(tag);
  endtask

  task automatic doWrite(input logic [6:0] a, input logic [7:0] d);
    step(a, ON, 1'b1, 1'b0, ~d, 1'b0, 8'h00, "R5 R6 write-low");
    step(a, ON, 1'b1, 1'b1, d, 1'b0, 8'h00, "R5 R7 write-rise");
    model[a] = d;
  endtask

  task automatic doRead(input logic [6:0] a, input string tag);
    step(a, ON, 1'b0, 1'b1, 8'h00, 1'b1, model[a], tag);
  endtask

  // scoreboard monitor
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (expOeQ.size() > 0) begin
        logic eOe;
        logic [7:0] eData;
        string tag;
        eOe = expOeQ.pop_front();
        eData = expDataQ.pop_front();
        tag = tagQ.pop_front();
        checks++;
        if (dataOe !== eOe || dataOut !== eData) begin
          errors++;
          $display("FAIL %s: oe=%0b data=%02h expected oe=%0b data=%02h", tag, dataOe, dataOut, eOe, eData);
        end
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run hung, actual=expired expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk);
    #2;
    checks++;
    if (dataOe !== 1'b0 || dataOut !== 8'h00) begin
      errors++;
      $display("FAIL R10 reset: oe=%0b data=%02h expected oe=0 data=00", dataOe, dataOut);
    end

    // fill every word, write-low data differs from committed data (R5)
    for (int a = 0; a < 128; a++) doWrite(7'(a), 8'((a * 29 + 7) & 8'hff));

    // read sweep, address changes every cycle (R3 R4)
    for (int a = 127; a >= 0; a--) doRead(7'(a), "R3 R4 sweep");
    doRead(7'd40, "R4 hold");
    doRead(7'd40, "R4 hold");

    // each select line inactive while reading (R1 R2)
    for (int i = 0; i < 5; i++)
      step(7'd9, ON ^ (5'b1 << i), 1'b0, 1'b1, 8'h00, 1'b0, 8'h00, "R1 R2 deselect");
    step(7'd9, 5'b01101, 1'b0, 1'b1, 8'h00, 1'b0, 8'h00, "R1 R2 all inverted");
    doRead(7'd9, "R1 selected");

    // write attempt while deselected stores nothing (R2)
    step(7'd10, ON ^ 5'b00100, 1'b1, 1'b0, 8'hC3, 1'b0, 8'h00, "R2 desel write-low");
    step(7'd10, ON ^ 5'b00100, 1'b1, 1'b1, 8'hC3, 1'b0, 8'h00, "R2 desel rise");
    step(7'd10, ON, 1'b1, 1'b1, 8'hC3, 1'b0, 8'h00, "R2 R7 standby");
    doRead(7'd10, "R2 unchanged");

    // conflicting strobes (R8)
    step(7'd5, ON, 1'b1, 1'b0, 8'hAA, 1'b0, 8'h00, "R6 write-low");
    step(7'd5, ON, 1'b0, 1'b0, 8'hAA, 1'b0, 8'h00, "R8 both low");
    step(7'd5, ON, 1'b1, 1'b1, 8'hAA, 1'b0, 8'h00, "R8 standby");
    doRead(7'd5, "R8 unchanged");

    // write rise coinciding with deselect (R9)
    step(7'd6, ON, 1'b1, 1'b0, 8'h55, 1'b0, 8'h00, "R6 write-low");
    step(7'd6, ON ^ 5'b00001, 1'b1, 1'b1, 8'h55, 1'b0, 8'h00, "R9 desel rise");
    step(7'd6, ON, 1'b1, 1'b1, 8'h55, 1'b0, 8'h00, "R9 standby");
    doRead(7'd6, "R9 unchanged desel");

    // write rise with read strobe low (R9)
    step(7'd7, ON, 1'b1, 1'b0, 8'h66, 1'b0, 8'h00, "R6 write-low");
    step(7'd7, ON, 1'b0, 1'b1, 8'h66, 1'b1, model[7], "R9 read on rise");
    step(7'd7, ON, 1'b1, 1'b1, 8'h66, 1'b0, 8'h00, "R9 standby");
    doRead(7'd7, "R9 unchanged read");

    // standby does not disturb contents (R7 R11)
    for (int i = 0; i < 4; i++)
      step(7'(i), ON, 1'b1, 1'b1, 8'(8'h11 * i), 1'b0, 8'h00, "R7 R11 standby");
    for (int i = 0; i < 4; i++) doRead(7'(i), "R7 intact");

    // overwrite then read back immediately (R5)
    doWrite(7'd127, 8'h00);
    doRead(7'd127, "R5 read after write");
    doWrite(7'd0, 8'hFF);
    doRead(7'd0, "R5 read after write");
    doRead(7'd127, "R5 neighbour");

    step(7'd0, ON, 1'b1, 1'b1, 8'h00, 1'b0, 8'h00, "R11 idle");
    repeat (3) @(posedge clk);
    #3;
    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule